// File: doc/BRIEF.md
# Interrupt Priority Arbiter with Fast-Transfer Routing

This block takes a set of peripheral interrupt request lines and, on every clock, picks the one pending source that should be served next. Each source has three settings. The first is a priority level, where zero disables the source. The second is a small group level that breaks ties between equal levels. The third is a routing flag. The routing flag sends the source either to a single-cycle data-transfer engine, on a configured channel, or to the processor as an ordinary interrupt carrying a source-specific vector index.

Only the processor path is gated by the running processor priority level. A request routed there can win only when its level is strictly above that level. A request routed to a transfer channel is never held back by it. When the transfer engine reports that a channel's transfer count is used up, the sources mapped to that channel are treated as processor requests, so the final transfer can be followed by a normal interrupt. The block raises at most one grant per cycle from registered outputs. The grant is cleared from the pending set when the receiver acknowledges the source that is currently shown.

Top module: `irq_route_arb`

## Requirements
- R1: During reset and on the first cycle after it, `xfer_req` and `cpu_irq` are low, and every channel, source, vector and level output is zero. No request that was pending before the reset survives it.
- R2: A pulse on `irq_in[i]` in cycle c marks source i pending at the end of c. The grant that results is visible on the outputs from cycle c+2. The source stays pending until it is acknowledged.
- R3: A source whose configured level is 0 never receives a grant, whatever its routing.
- R4: Among the eligible pending sources, the highest level wins. On equal levels, the higher group level wins. On equal level and group, the lower source index wins.
- R5: When the winner is routed to fast transfer (`cfg_fast[i]`=1) and `chan_empty` is 0 for its channel, `xfer_req` is 1, `xfer_chan` carries the configured 3-bit channel of the winner, `xfer_src` carries its index, and `cpu_irq` is 0. While `xfer_req` is 0, `xfer_chan` and `xfer_src` are 0.
- R6: A source on the processor path is eligible only if its level is strictly greater than `cpu_level`. When it wins, `cpu_irq` is 1, `cpu_vector` equals its source index, and `cpu_irq_level` equals its level. While `cpu_irq` is 0, both fields are 0.
- R7: A processor-path source that is blocked by `cpu_level` takes no part in arbitration. A lower-ranked fast-transfer source is granted as if the blocked source were absent.
- R8: A fast-transfer source whose channel has its `chan_empty` bit at 1 is handled exactly as a processor-path source, subject to R6.
- R9: `xfer_req` and `cpu_irq` are never 1 in the same cycle.
- R10: `xfer_ack` while `xfer_req`=1, or `cpu_ack` while `cpu_irq`=1, clears the pending flag of the shown source, and that source does not appear on the next cycle's outputs. An `irq_in` for that source in the same cycle makes it pending again. An acknowledge while the matching request is 0 has no effect.
- R11: Arbitration is repeated every cycle. An unacknowledged grant is replaced on the outputs when a better-ranked source becomes pending, or when a change in configuration or in `cpu_level` changes the winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_in | input | NUM_SRC | Request pulses, one per source; a 1 sets that source's pending flag |
| cfg_level | input | NUM_SRC*LVL_W | Priority level per source, 0 disables; source i at bits i*LVL_W upward |
| cfg_group | input | NUM_SRC*GRP_W | Tie-break group level per source; source i at bits i*GRP_W upward |
| cfg_fast | input | NUM_SRC | 1 routes the source to the transfer engine, 0 to the processor |
| cfg_chan | input | NUM_SRC*CH_W | Transfer channel per source; source i at bits i*CH_W upward |
| chan_empty | input | NUM_CH | 1 marks a channel whose transfer count is exhausted |
| cpu_level | input | LVL_W | Current processor priority level |
| xfer_req | output | 1 | Transfer request |
| xfer_chan | output | CH_W | Channel for the transfer request |
| xfer_src | output | IDX_W | Source index for the transfer request |
| xfer_ack | input | 1 | Transfer engine accepts the shown request |
| cpu_irq | output | 1 | Interrupt request to the processor |
| cpu_vector | output | IDX_W | Vector index, equal to the source index |
| cpu_irq_level | output | LVL_W | Level of the source being presented |
| cpu_ack | input | 1 | Processor accepts the shown interrupt |

## Verification
The hardest situation to reach is the acknowledge cycle in which the acknowledged source pulses `irq_in` again. In that same cycle a second source is contending, `cpu_level` is masking some requests, and a channel has just been flagged empty. All of these decide the winner of the following cycle together. A directed case sets up the acknowledge with a simultaneous re-request and checks both the one-cycle gap and the reappearance. A long pseudo-random run then drives overlapping request pulses, acknowledges on either path (some of them stray), changing `cpu_level`, changing empty flags and periodic reconfiguration. A cycle-accurate score model in the bench ranks sources by an arithmetic score and is compared against every output on every cycle. Exhaustive sweeps over level against `cpu_level`, and over ordered source pairs under four tie patterns, cover the gating and ordering rules.

// File: rtl/irq_arb_pkg.sv
// Package irq_arb_pkg
// Holds the default sizes of the arbiter and the route type that the
// grant stage uses to name its decision. It has no logic of its own.
package irq_arb_pkg;

    localparam int DEF_NUM_SRC = 16;
    localparam int DEF_LVL_W   = 4;
    localparam int DEF_GRP_W   = 2;
    localparam int DEF_NUM_CH  = 8;

    // Destination chosen for the winner of one arbitration round.
    typedef enum logic [1:0] {
        ROUTE_IDLE = 2'd0,
        ROUTE_XFER = 2'd1,
        ROUTE_CPU  = 2'd2
    } route_e;

endpackage

// File: rtl/irq_pend_bank.sv
// Module irq_pend_bank
// Holds one pending flag per source. A flag is set by an irq_in pulse and
// cleared when the receiver acknowledges the source currently shown on
// either grant path. The output pend_eff already excludes a source that is
// being acknowledged in this cycle, so the next round cannot grant it again.
// Assumes: at most one of xfer_req and cpu_irq is high (guaranteed upstream).
module irq_pend_bank #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     irq_in,
    input  logic             xfer_ack,
    input  logic             xfer_req,
    input  logic [IDX_W-1:0] xfer_src,
    input  logic             cpu_ack,
    input  logic             cpu_irq,
    input  logic [IDX_W-1:0] cpu_vector,
    output logic [N-1:0]     pend_eff
);

    logic xfer_take;
    logic cpu_take;

    // Acknowledge counts only while the matching request is being shown.
    always_comb begin
        xfer_take = xfer_ack && xfer_req;
        cpu_take  = cpu_ack && cpu_irq;
    end

    for (genvar i = 0; i < N; i++) begin : g_src
        logic flag_q;
        logic clr;

        // Decode whether this source is the one being acknowledged now.
        always_comb begin
            clr = (xfer_take && (xfer_src == IDX_W'(i))) ||
                  (cpu_take  && (cpu_vector == IDX_W'(i)));
        end

        // Pending flag: cleared by acknowledge, set by a request pulse.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q <= 1'b0;
            end else begin
                flag_q <= (flag_q && !clr) || irq_in[i];
            end
        end

        assign pend_eff[i] = flag_q && !clr;
    end

endmodule

// File: rtl/irq_src_qual.sv
// Module irq_src_qual
// Decides per source whether it may take part in this round and builds its
// ranking key. A source qualifies when it is pending, has a non-zero level,
// and is either served by a live transfer channel or outranks the processor.
// Assumes: NUM_CH is a power of two so every channel code selects a flag.
module irq_src_qual #(
    parameter int N      = 16,
    parameter int LVL_W  = 4,
    parameter int GRP_W  = 2,
    parameter int NUM_CH = 8,
    parameter int CH_W   = 3,
    parameter int KEY_W  = LVL_W + GRP_W
) (
    input  logic [N-1:0]       pend_eff,
    input  logic [N*LVL_W-1:0] cfg_level,
    input  logic [N*GRP_W-1:0] cfg_group,
    input  logic [N-1:0]       cfg_fast,
    input  logic [N*CH_W-1:0]  cfg_chan,
    input  logic [NUM_CH-1:0]  chan_empty,
    input  logic [LVL_W-1:0]   cpu_level,
    output logic [N-1:0]       elig,
    output logic [N-1:0]       fast_ok,
    output logic [N*KEY_W-1:0] key
);

    for (genvar i = 0; i < N; i++) begin : g_src
        logic [LVL_W-1:0] lvl;
        logic [GRP_W-1:0] grp;
        logic [CH_W-1:0]  ch;
        logic             live;
        logic             above_cpu;

        // Slice this source's settings out of the packed configuration.
        always_comb begin
            lvl = cfg_level[i*LVL_W +: LVL_W];
            grp = cfg_group[i*GRP_W +: GRP_W];
            ch  = cfg_chan[i*CH_W +: CH_W];
        end

        // Route and gating: exhausted channels fall back to the CPU path.
        always_comb begin
            live       = (lvl != '0);
            above_cpu  = (lvl > cpu_level);
            fast_ok[i] = cfg_fast[i] && !chan_empty[ch];
            elig[i]    = pend_eff[i] && live && (fast_ok[i] || above_cpu);
            key[i*KEY_W +: KEY_W] = {lvl, grp};
        end
    end

endmodule

// File: rtl/irq_prio_tree.sv
// Module irq_prio_tree
// Balanced compare tree that returns the eligible source with the largest
// key. Leaves are laid out by ascending index, and a node keeps its left
// child on an equal key, so the lower index wins a full tie without carrying
// index bits in the key. Depth is ceil(log2(N)) compare levels.
// Assumes: N >= 2.
module irq_prio_tree #(
    parameter int N     = 16,
    parameter int KEY_W = 6,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]       elig,
    input  logic [N*KEY_W-1:0] key,
    output logic               win_valid,
    output logic [IDX_W-1:0]   win_idx
);

    localparam int LEAVES = 1 << $clog2(N);
    localparam int NODES  = 2 * LEAVES - 1;

    // Heap-ordered tree: node k has children 2k+1 and 2k+2, leaves at the end.
    always_comb begin
        logic             nv [0:NODES-1];
        logic [KEY_W-1:0] nk [0:NODES-1];
        logic [IDX_W-1:0] ni [0:NODES-1];
        logic             take_left;

        for (int n = 0; n < NODES; n++) begin
            nv[n] = 1'b0;
            nk[n] = '0;
            ni[n] = '0;
        end
        for (int i = 0; i < N; i++) begin
            nv[LEAVES-1+i] = elig[i];
            nk[LEAVES-1+i] = key[i*KEY_W +: KEY_W];
            ni[LEAVES-1+i] = IDX_W'(i);
        end
        for (int k = LEAVES - 2; k >= 0; k--) begin
            take_left = nv[2*k+1] && (!nv[2*k+2] || (nk[2*k+1] >= nk[2*k+2]));
            nv[k] = take_left ? nv[2*k+1] : nv[2*k+2];
            nk[k] = take_left ? nk[2*k+1] : nk[2*k+2];
            ni[k] = take_left ? ni[2*k+1] : ni[2*k+2];
        end
        win_valid = nv[0];
        win_idx   = ni[0];
    end

endmodule

// File: rtl/irq_grant_reg.sv
// Module irq_grant_reg
// Turns the round winner into a registered grant on exactly one path. A
// winner with a live transfer channel drives the transfer outputs; any other
// winner has already passed the CPU level gate and drives the interrupt
// outputs. Fields of an idle path are held at zero.
// Assumes: win_idx < N whenever win_valid is high.
module irq_grant_reg #(
    parameter int N     = 16,
    parameter int LVL_W = 4,
    parameter int CH_W  = 3,
    parameter int IDX_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               win_valid,
    input  logic [IDX_W-1:0]   win_idx,
    input  logic [N-1:0]       fast_ok,
    input  logic [N*LVL_W-1:0] cfg_level,
    input  logic [N*CH_W-1:0]  cfg_chan,
    output logic               xfer_req,
    output logic [CH_W-1:0]    xfer_chan,
    output logic [IDX_W-1:0]   xfer_src,
    output logic               cpu_irq,
    output logic [IDX_W-1:0]   cpu_vector,
    output logic [LVL_W-1:0]   cpu_irq_level
);

    import irq_arb_pkg::*;

    route_e           route;
    logic [LVL_W-1:0] sel_lvl;
    logic [CH_W-1:0]  sel_ch;

    // Pick the destination and the winner's settings.
    always_comb begin
        sel_lvl = cfg_level[win_idx*LVL_W +: LVL_W];
        sel_ch  = cfg_chan[win_idx*CH_W +: CH_W];
        if (!win_valid)
            route = ROUTE_IDLE;
        else if (fast_ok[win_idx])
            route = ROUTE_XFER;
        else
            route = ROUTE_CPU;
    end

    // Register the grant; only the chosen path carries non-zero fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_req      <= 1'b0;
            xfer_chan     <= '0;
            xfer_src      <= '0;
            cpu_irq       <= 1'b0;
            cpu_vector    <= '0;
            cpu_irq_level <= '0;
        end else begin
            xfer_req      <= (route == ROUTE_XFER);
            xfer_chan     <= (route == ROUTE_XFER) ? sel_ch  : '0;
            xfer_src      <= (route == ROUTE_XFER) ? win_idx : '0;
            cpu_irq       <= (route == ROUTE_CPU);
            cpu_vector    <= (route == ROUTE_CPU)  ? win_idx : '0;
            cpu_irq_level <= (route == ROUTE_CPU)  ? sel_lvl : '0;
        end
    end

endmodule

// File: rtl/irq_route_arb.sv
// Module irq_route_arb (top)
// Interrupt priority arbiter with two destinations: a single-cycle transfer
// engine and the processor. Pending flags feed a qualification stage that
// applies the level-0 disable, the CPU level gate and the exhausted-channel
// fallback. A compare tree picks one winner per cycle, and a register stage
// presents it on one path. Latency from request pulse to grant is two cycles.
// Assumes: NUM_SRC >= 2, NUM_CH a power of two, acknowledges refer to the
// grant shown in the same cycle.
module irq_route_arb #(
    parameter int NUM_SRC = irq_arb_pkg::DEF_NUM_SRC,
    parameter int LVL_W   = irq_arb_pkg::DEF_LVL_W,
    parameter int GRP_W   = irq_arb_pkg::DEF_GRP_W,
    parameter int NUM_CH  = irq_arb_pkg::DEF_NUM_CH,
    localparam int IDX_W  = $clog2(NUM_SRC),
    localparam int CH_W   = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       irq_in,
    input  logic [NUM_SRC*LVL_W-1:0] cfg_level,
    input  logic [NUM_SRC*GRP_W-1:0] cfg_group,
    input  logic [NUM_SRC-1:0]       cfg_fast,
    input  logic [NUM_SRC*CH_W-1:0]  cfg_chan,
    input  logic [NUM_CH-1:0]        chan_empty,
    input  logic [LVL_W-1:0]         cpu_level,
    output logic                     xfer_req,
    output logic [CH_W-1:0]          xfer_chan,
    output logic [IDX_W-1:0]         xfer_src,
    input  logic                     xfer_ack,
    output logic                     cpu_irq,
    output logic [IDX_W-1:0]         cpu_vector,
    output logic [LVL_W-1:0]         cpu_irq_level,
    input  logic                     cpu_ack
);

    localparam int KEY_W = LVL_W + GRP_W;

    logic [NUM_SRC-1:0]       pend_eff;
    logic [NUM_SRC-1:0]       elig;
    logic [NUM_SRC-1:0]       fast_ok;
    logic [NUM_SRC*KEY_W-1:0] key;
    logic                     win_valid;
    logic [IDX_W-1:0]         win_idx;

    irq_pend_bank #(
        .N     (NUM_SRC),
        .IDX_W (IDX_W)
    ) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_in     (irq_in),
        .xfer_ack   (xfer_ack),
        .xfer_req   (xfer_req),
        .xfer_src   (xfer_src),
        .cpu_ack    (cpu_ack),
        .cpu_irq    (cpu_irq),
        .cpu_vector (cpu_vector),
        .pend_eff   (pend_eff)
    );

    irq_src_qual #(
        .N      (NUM_SRC),
        .LVL_W  (LVL_W),
        .GRP_W  (GRP_W),
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W),
        .KEY_W  (KEY_W)
    ) u_qual (
        .pend_eff   (pend_eff),
        .cfg_level  (cfg_level),
        .cfg_group  (cfg_group),
        .cfg_fast   (cfg_fast),
        .cfg_chan   (cfg_chan),
        .chan_empty (chan_empty),
        .cpu_level  (cpu_level),
        .elig       (elig),
        .fast_ok    (fast_ok),
        .key        (key)
    );

    irq_prio_tree #(
        .N     (NUM_SRC),
        .KEY_W (KEY_W),
        .IDX_W (IDX_W)
    ) u_tree (
        .elig      (elig),
        .key       (key),
        .win_valid (win_valid),
        .win_idx   (win_idx)
    );

    irq_grant_reg #(
        .N     (NUM_SRC),
        .LVL_W (LVL_W),
        .CH_W  (CH_W),
        .IDX_W (IDX_W)
    ) u_grant (
        .clk           (clk),
        .rst_n         (rst_n),
        .win_valid     (win_valid),
        .win_idx       (win_idx),
        .fast_ok       (fast_ok),
        .cfg_level     (cfg_level),
        .cfg_chan      (cfg_chan),
        .xfer_req      (xfer_req),
        .xfer_chan     (xfer_chan),
        .xfer_src      (xfer_src),
        .cpu_irq       (cpu_irq),
        .cpu_vector    (cpu_vector),
        .cpu_irq_level (cpu_irq_level)
    );

endmodule

// File: rtl/irq_route_arb_chk.sv
// Module irq_route_arb_chk
// Property checker for irq_route_arb, attached by the bind below. It only
// observes ports; one local register keeps last cycle's channel-empty flags.
module irq_route_arb_chk #(
    parameter int NUM_SRC = 16,
    parameter int LVL_W   = 4,
    parameter int NUM_CH  = 8,
    parameter int IDX_W   = 4,
    parameter int CH_W    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] chan_empty,
    input logic [LVL_W-1:0]  cpu_level,
    input logic              xfer_req,
    input logic [CH_W-1:0]   xfer_chan,
    input logic [IDX_W-1:0]  xfer_src,
    input logic              xfer_ack,
    input logic              cpu_irq,
    input logic [IDX_W-1:0]  cpu_vector,
    input logic [LVL_W-1:0]  cpu_irq_level,
    input logic              cpu_ack
);

    logic [NUM_CH-1:0] empty_q;

    // Keep the empty flags that the previous arbitration round saw.
    always_ff @(posedge clk) begin
        if (!rst_n) empty_q <= '0;
        else        empty_q <= chan_empty;
    end

    p_one_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer_req && cpu_irq));

    p_cpu_above_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> (cpu_irq_level > $past(cpu_level)));

    p_live_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> (cpu_irq_level != '0));

    p_live_chan_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> !empty_q[xfer_chan]);

    p_idle_xfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_req |-> (xfer_chan == '0 && xfer_src == '0));

    p_cpu_ack_gone_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && cpu_irq) |=> !(cpu_irq && cpu_vector == $past(cpu_vector)));

    p_xfer_ack_gone_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_ack && xfer_req) |=> !(xfer_req && xfer_src == $past(xfer_src)));

endmodule

bind irq_route_arb irq_route_arb_chk #(
    .NUM_SRC (NUM_SRC),
    .LVL_W   (LVL_W),
    .NUM_CH  (NUM_CH),
    .IDX_W   (IDX_W),
    .CH_W    (CH_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .chan_empty    (chan_empty),
    .cpu_level     (cpu_level),
    .xfer_req      (xfer_req),
    .xfer_chan     (xfer_chan),
    .xfer_src      (xfer_src),
    .xfer_ack      (xfer_ack),
    .cpu_irq       (cpu_irq),
    .cpu_vector    (cpu_vector),
    .cpu_irq_level (cpu_irq_level),
    .cpu_ack       (cpu_ack)
);

// File: tb/sim_irq_route_arb.sv
`timescale 1ns/1ps
module sim_irq_route_arb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] irq;
    logic [63:0] lvlv;
    logic [31:0] grpv;
    logic [15:0] fastv;
    logic [47:0] chv;
    logic [7:0]  emp;
    logic [3:0]  cpul;
    logic        xack, cack;
    logic        xfer_req, cpu_irq;
    logic [2:0]  xfer_chan;
    logic [3:0]  xfer_src, cpu_vector, cpu_irq_level;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    // score model state
    logic [15:0] mpend;
    logic        e_xr, e_ci;
    logic [2:0]  e_xc;
    logic [3:0]  e_xs, e_cv, e_cl;

    always #2.5 clk = ~clk;

    irq_route_arb u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq), .cfg_level(lvlv),
        .cfg_group(grpv), .cfg_fast(fastv), .cfg_chan(chv),
        .chan_empty(emp), .cpu_level(cpul),
        .xfer_req(xfer_req), .xfer_chan(xfer_chan), .xfer_src(xfer_src),
        .xfer_ack(xack), .cpu_irq(cpu_irq), .cpu_vector(cpu_vector),
        .cpu_irq_level(cpu_irq_level), .cpu_ack(cack)
    );

    // Reference: rank by score level*64 + group*16 + (15 - index).
    task automatic model_edge();
        logic [15:0] clr, eff;
        int best, bs, sc;
        logic bfast;
        if (!rst_n) begin
            mpend = '0; e_xr = 0; e_xc = 0; e_xs = 0; e_ci = 0; e_cv = 0; e_cl = 0;
            return;
        end
        clr = '0;
        if (xack && e_xr) clr[e_xs] = 1'b1;
        else if (cack && e_ci) clr[e_cv] = 1'b1;
        eff = mpend & ~clr;
        best = -1; bs = -1; bfast = 0;
        for (int i = 0; i < 16; i++) begin
            int l, g, c;
            logic fo;
            l = int'(lvlv[i*4 +: 4]);
            g = int'(grpv[i*2 +: 2]);
            c = int'(chv[i*3 +: 3]);
            fo = fastv[i] && !emp[c];
            if (eff[i] && l != 0 && (fo || l > int'(cpul))) begin
                sc = l * 64 + g * 16 + (15 - i);
                if (sc > bs) begin bs = sc; best = i; bfast = fo; end
            end
        end
        e_xr = 0; e_xc = 0; e_xs = 0; e_ci = 0; e_cv = 0; e_cl = 0;
        if (best >= 0) begin
            if (bfast) begin
                e_xr = 1; e_xc = chv[best*3 +: 3]; e_xs = 4'(best);
            end else begin
                e_ci = 1; e_cv = 4'(best); e_cl = lvlv[best*4 +: 4];
            end
        end
        mpend = eff | irq;
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic xr, input logic [2:0] xc,
                       input logic [3:0] xs, input logic ci, input logic [3:0] cv,
                       input logic [3:0] cl);
        n_vec++;
        if ({xfer_req, xfer_chan, xfer_src, cpu_irq, cpu_vector, cpu_irq_level}
            !== {xr, xc, xs, ci, cv, cl}) begin
            n_bad++;
            $display("FAIL %s: got xfer=%0b ch=%0d src=%0d cpu=%0b vec=%0d lvl=%0d, expected xfer=%0b ch=%0d src=%0d cpu=%0b vec=%0d lvl=%0d",
                     tag, xfer_req, xfer_chan, xfer_src, cpu_irq, cpu_vector, cpu_irq_level,
                     xr, xc, xs, ci, cv, cl);
        end
    endtask

    task automatic check_model(input string tag);
        chk(tag, e_xr, e_xc, e_xs, e_ci, e_cv, e_cl);
        n_vec++;
        if (xfer_req && cpu_irq) begin
            n_bad++;
            $display("FAIL R9: got xfer=1 cpu=1, expected at most one grant");
        end
    endtask

    task automatic clear_cfg();
        irq = 0; lvlv = 0; grpv = 0; fastv = 0; chv = 0; emp = 0; cpul = 0;
        xack = 0; cack = 0;
    endtask

    task automatic set_src(input int i, input int l, input int g, input bit f, input int c);
        lvlv[i*4 +: 4] = 4'(l);
        grpv[i*2 +: 2] = 2'(g);
        fastv[i]       = f;
        chv[i*3 +: 3]  = 3'(c);
    endtask

    task automatic do_reset();
        rst_n = 0;
        step();
        check_model("R1");
        rst_n = 1;
    endtask

    initial begin
        clear_cfg();
        rst_n = 0;
        @(negedge clk);
        step(); step();
        chk("R1", 0, 0, 0, 0, 0, 0);
        rst_n = 1;
        step();
        chk("R1", 0, 0, 0, 0, 0, 0);

        // R3 / R6: level against CPU level, every pair, three sources
        for (int s = 0; s < 3; s++) begin
            for (int lv = 0; lv < 16; lv++) begin
                for (int cl = 0; cl < 16; cl++) begin
                    int src;
                    src = (s == 0) ? 0 : (s == 1) ? 7 : 15;
                    do_reset();
                    clear_cfg();
                    set_src(src, lv, s, 0, 0);
                    cpul = 4'(cl);
                    irq[src] = 1;
                    step(); check_model("R2");
                    irq = 0;
                    step();
                    if (lv == 0) chk("R3", 0, 0, 0, 0, 0, 0);
                    else if (lv > cl) chk("R6", 0, 0, 0, 1, 4'(src), 4'(lv));
                    else chk("R6", 0, 0, 0, 0, 0, 0);
                    if (e_ci) begin
                        cack = 1; step(); check_model("R10"); cack = 0;
                    end
                end
            end
        end

        // R4: ordering over every ordered pair of sources, four tie patterns
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                if (a == b) continue;
                for (int p = 0; p < 4; p++) begin
                    do_reset();
                    clear_cfg();
                    case (p)
                        0: begin set_src(a, 6, 1, 0, 0); set_src(b, 6, 1, 0, 0); end
                        1: begin set_src(a, 9, 0, 0, 0); set_src(b, 4, 3, 0, 0); end
                        2: begin set_src(a, 5, 0, 0, 0); set_src(b, 5, 2, 0, 0); end
                        default: begin set_src(a, 5, 2, 1, a % 8); set_src(b, 5, 2, 1, b % 8); end
                    endcase
                    irq[a] = 1; irq[b] = 1;
                    step(); irq = 0;
                    step(); check_model("R4");
                    if (e_xr) xack = 1; else cack = 1;
                    step(); check_model("R10");
                    xack = 0; cack = 0;
                    step(); check_model("R4");
                end
            end
        end

        // R7: blocked CPU source does not hide a lower fast source
        do_reset(); clear_cfg();
        set_src(2, 10, 3, 0, 0); set_src(9, 3, 0, 1, 5); cpul = 12;
        irq[2] = 1; irq[9] = 1; step(); irq = 0;
        step(); chk("R7", 1, 5, 9, 0, 0, 0);

        // R8: exhausted channel falls back to the CPU path
        do_reset(); clear_cfg();
        set_src(4, 7, 1, 1, 2); emp[2] = 1; cpul = 3;
        irq[4] = 1; step(); irq = 0;
        step(); chk("R8", 0, 0, 0, 1, 4, 7);
        emp[2] = 0;
        step(); chk("R8", 1, 2, 4, 0, 0, 0);

        // R10: stray ack, then ack with simultaneous re-request
        do_reset(); clear_cfg();
        set_src(6, 5, 0, 0, 0);
        irq[6] = 1; step(); irq = 0;
        step(); chk("R10", 0, 0, 0, 1, 6, 5);
        xack = 1; step(); xack = 0;
        chk("R10", 0, 0, 0, 1, 6, 5);
        cack = 1; irq[6] = 1; step(); cack = 0; irq = 0;
        chk("R10", 0, 0, 0, 0, 0, 0);
        step(); chk("R10", 0, 0, 0, 1, 6, 5);

        // R11: preemption of an unacknowledged grant
        do_reset(); clear_cfg();
        set_src(1, 2, 0, 0, 0); set_src(3, 8, 0, 0, 0);
        irq[1] = 1; step(); irq = 0;
        step(); chk("R11", 0, 0, 0, 1, 1, 2);
        irq[3] = 1; step(); irq = 0;
        chk("R11", 0, 0, 0, 1, 1, 2);
        step(); chk("R11", 0, 0, 0, 1, 3, 8);
        cpul = 9;
        step(); chk("R11", 0, 0, 0, 0, 0, 0);

        // R11 / R5: long pseudo-random run against the score model
        do_reset(); clear_cfg();
        void'($urandom(32'h5eed));
        for (int cyc = 0; cyc < 20000; cyc++) begin
            if (cyc % 64 == 0) begin
                lvlv  = {$urandom, $urandom};
                grpv  = $urandom;
                fastv = 16'($urandom);
                chv   = {16'($urandom), $urandom};
            end
            if (cyc % 16 == 0) cpul = 4'($urandom);
            if (cyc % 32 == 0) emp = 8'($urandom);
            irq  = 16'($urandom & $urandom & $urandom);
            xack = 1'($urandom);
            cack = 1'($urandom);
            step();
            check_model(xfer_req ? "R5" : "R11");
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got no completion, expected finish before timeout");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule